// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block turns two logic-level switching commands, one for the high-side and one for the low-side switch of a half-bridge, into two registered gate-enable outputs. It runs in one of two modes, picked at reset. In independent mode each output follows its own command. In differential mode the two commands are decoded as a pair, so that the two outputs are never on together.

Two undervoltage flags gate the outputs. The main-supply flag turns both outputs off. The bootstrap-supply flag turns the high side off. When the bootstrap flag clears, the high side stays locked out for a fixed interval. After that interval it re-arms only once its command has been seen low, so the first pulse it passes is a whole pulse. A switch-node slew flag freezes the high-side output. The most recent commanded level is applied as soon as the flag drops.

All flags arrive already synchronised to the clock. Intervals are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `hb_gate_seq`

## Requirements
- R1: With `mode_diff_i` low at reset (independent mode), `gate_lo_o` follows `cmd_lo_i` and `gate_hi_o` follows `cmd_hi_i`, each with no influence from the other channel.
- R2: With `mode_diff_i` high at reset (differential mode), the command pair (hi,lo) maps to outputs (hi,lo) as follows: (0,0)→(0,0), (1,0)→(1,0), (0,1)→(0,1), (1,1)→(0,0).
- R3: While `uv_main_i` is high, both outputs are low one cycle later.
- R4: While `uv_boot_i` is high, `gate_hi_o` is low one cycle later. `gate_lo_o` is not affected.
- R5: After `uv_boot_i` falls, the high side stays locked out for LOCK_CYC = ceil(LOCK_NS × CLK_HZ / 1e9) cycles (1250 at the defaults). A new assertion of `uv_boot_i` restarts the count.
- R6: Once the hold-off has expired, the high side stays blocked while its decoded command is high. It is released only after that command has been observed low.
- R7: While `slew_i` is high, `gate_hi_o` does not change. When `slew_i` falls, the latest high-side command level appears on `gate_hi_o` one cycle later. Any toggles made during the freeze are collapsed into that latest level.
- R8: While `rst_n` is low (synchronous, active low), both outputs are low. Reset also engages the high-side lockout as if the bootstrap flag had just cleared.
- R9: `mode_diff_i` is sampled only during reset. Changing it during operation has no effect.
- R10: In differential mode the two outputs are never high in the same cycle. This holds during command transitions and while the high side is frozen.
- R11: Each output has one cycle of latency. A command pulse of N cycles gives an output pulse of exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_diff_i | input | 1 | Mode select: 1 = differential, 0 = independent (sampled during reset) |
| cmd_hi_i | input | 1 | High-side switching command |
| cmd_lo_i | input | 1 | Low-side switching command |
| uv_main_i | input | 1 | Main supply undervoltage flag |
| uv_boot_i | input | 1 | Bootstrap supply undervoltage flag |
| slew_i | input | 1 | Switch-node fast-slew flag |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |

## Verification
The assertions check the following on every cycle:
- the undervoltage forcing of each output;
- the one-cycle follow of the low side in independent mode;
- the freeze of the high side while slew is flagged;
- the exclusion of simultaneous outputs in differential mode;
- the still-blocked cycle right after the bootstrap flag falls.

Other behaviours show only in the bench's scenarios, because each depends on a history longer than a property can reasonably hold:
- the length of the hold-off and its restart;
- re-arming only after a low command;
- collapsing several toggles made during a freeze into the latest level;
- mode latching at reset;
- equal output and input pulse widths.

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned LOCK_NS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_diff_i,
  input  logic cmd_hi_i,
  input  logic cmd_lo_i,
  input  logic uv_main_i,
  input  logic uv_boot_i,
  input  logic slew_i,
  output logic gate_hi_o,
  output logic gate_lo_o
);

  localparam longint unsigned PROD = longint'(CLK_HZ) * longint'(LOCK_NS);
  localparam int unsigned LOCK_RAW = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int unsigned LOCK_CYC = (LOCK_RAW < 1) ? 1 : LOCK_RAW;
  localparam int unsigned CNT_W    = $clog2(LOCK_CYC + 1);

  typedef enum logic [1:0] {LK_WAIT, LK_ARM, LK_RUN} lk_t;

  lk_t              lk;
  logic [CNT_W-1:0] cnt;
  logic             mode_q, gate_hi_q, gate_lo_q;
  logic             want_hi, want_lo, hi_nxt, lo_nxt;

  assign want_hi = cmd_hi_i & ~(mode_q & cmd_lo_i);
  assign want_lo = cmd_lo_i & ~(mode_q & cmd_hi_i);

  assign hi_nxt = (uv_main_i | uv_boot_i) ? 1'b0 :
                  slew_i                  ? gate_hi_q :
                                            (want_hi & (lk == LK_RUN));
  assign lo_nxt = ~uv_main_i & want_lo & ~(mode_q & hi_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= mode_diff_i;
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
      lk        <= LK_WAIT;
      cnt       <= CNT_W'(LOCK_CYC);
    end else begin
      gate_hi_q <= hi_nxt;
      gate_lo_q <= lo_nxt;
      if (uv_boot_i) begin
        lk  <= LK_WAIT;
        cnt <= CNT_W'(LOCK_CYC);
      end else begin
        case (lk)
          LK_WAIT: begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) lk <= LK_ARM;
          end
          LK_ARM:  if (!want_hi) lk <= LK_RUN;
          default: ;
        endcase
      end
    end
  end

  assign gate_hi_o = gate_hi_q;
  assign gate_lo_o = gate_lo_q;

endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_q,
  input logic cmd_lo_i,
  input logic uv_main_i,
  input logic uv_boot_i,
  input logic slew_i,
  input logic gate_hi_o,
  input logic gate_lo_o
);

  a_r3_main_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_main_i |=> (!gate_hi_o && !gate_lo_o));

  a_r4_boot_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_boot_i |=> !gate_hi_o);

  a_r5_still_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_boot_i) |=> !gate_hi_o);

  a_r7_slew_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_i && !uv_main_i && !uv_boot_i) |=> $stable(gate_hi_o));

  a_r1_lo_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !uv_main_i) |=> (gate_lo_o == $past(cmd_lo_i)));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !(gate_hi_o && gate_lo_o));

endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cmd_lo_i(cmd_lo_i),
  .uv_main_i(uv_main_i), .uv_boot_i(uv_boot_i), .slew_i(slew_i),
  .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
);

// File: tb/tb_hb_gate_seq.sv
module tb_hb_gate_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_diff_i = 1'b0, cmd_hi_i = 1'b0, cmd_lo_i = 1'b0;
  logic uv_main_i = 1'b0, uv_boot_i = 1'b0, slew_i = 1'b0;
  logic gate_hi_o, gate_lo_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  localparam int LOCK = 1250;

  always #2 clk = ~clk;

  hb_gate_seq dut (.*);

  // {mode, cmd_hi, cmd_lo, uv_main, exp_hi, exp_lo}
  localparam logic [5:0] VEC [0:11] = '{
    6'b0_00_0_00, 6'b0_10_0_10, 6'b0_01_0_01, 6'b0_11_0_11, 6'b0_11_1_00, 6'b0_10_0_10,
    6'b1_00_0_00, 6'b1_10_0_10, 6'b1_01_0_01, 6'b1_11_0_00, 6'b1_11_1_00, 6'b1_01_0_01
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic m);
    rst_n = 1'b0; mode_diff_i = m;
    cmd_hi_i = 0; cmd_lo_i = 0; uv_main_i = 0; uv_boot_i = 0; slew_i = 0;
    step(3);
    check("R8 hi in reset", gate_hi_o, 1'b0);
    check("R8 lo in reset", gate_lo_o, 1'b0);
    rst_n = 1'b1;
    cmd_hi_i = 1'b1;
    step(100);
    check("R8 lockout after reset", gate_hi_o, 1'b0);
    cmd_hi_i = 1'b0;
    step(LOCK + 20);
  endtask

  initial begin
    int cur, cnt;
    step(1);
    cur = -1;
    for (int i = 0; i < 12; i++) begin
      if (cur != int'(VEC[i][5])) begin
        do_reset(VEC[i][5]);
        cur = int'(VEC[i][5]);
      end
      cmd_hi_i = VEC[i][4]; cmd_lo_i = VEC[i][3]; uv_main_i = VEC[i][2];
      step(1);
      check(VEC[i][2] ? "R3 hi" : (VEC[i][5] ? "R2 hi" : "R1 hi"), gate_hi_o, VEC[i][1]);
      check(VEC[i][2] ? "R3 lo" : (VEC[i][5] ? "R2 lo" : "R1 lo"), gate_lo_o, VEC[i][0]);
    end

    // R9: mode change during operation is ignored
    do_reset(1'b0);
    mode_diff_i = 1'b1; cmd_hi_i = 1; cmd_lo_i = 1;
    step(1);
    check("R9 hi", gate_hi_o, 1'b1);
    check("R9 lo", gate_lo_o, 1'b1);

    // R11: pulse width preserved
    cmd_hi_i = 0; cmd_lo_i = 0; step(2);
    cnt = 0;
    cmd_lo_i = 1;
    for (int k = 0; k < 3; k++) begin step(1); cnt += int'(gate_lo_o); end
    cmd_lo_i = 0;
    for (int k = 0; k < 5; k++) begin step(1); cnt += int'(gate_lo_o); end
    check("R11 pulse width 3", cnt == 3, 1'b1);

    // R4: bootstrap UV forces high side low only
    cmd_hi_i = 1; cmd_lo_i = 1; step(1);
    check("R4 hi before", gate_hi_o, 1'b1);
    uv_boot_i = 1; step(1);
    check("R4 hi forced", gate_hi_o, 1'b0);
    check("R4 lo kept", gate_lo_o, 1'b1);
    cmd_lo_i = 0;

    // R6: command high through hold-off keeps high side blocked
    uv_boot_i = 0; step(LOCK + 150);
    check("R6 blocked while high", gate_hi_o, 1'b0);
    cmd_hi_i = 0; step(1);
    cmd_hi_i = 1; step(1);
    check("R6 released after low", gate_hi_o, 1'b1);

    // R5: raise command before hold-off ends
    cmd_hi_i = 0; uv_boot_i = 1; step(2);
    uv_boot_i = 0; step(1200);
    cmd_hi_i = 1; step(1);
    check("R5 inside hold-off", gate_hi_o, 1'b0);
    step(200);
    check("R6 still blocked", gate_hi_o, 1'b0);
    cmd_hi_i = 0; step(2);
    cmd_hi_i = 1; step(1);
    check("R6 release", gate_hi_o, 1'b1);

    // R5: release after full hold-off with command low
    cmd_hi_i = 0; uv_boot_i = 1; step(2);
    uv_boot_i = 0; step(LOCK + 50);
    cmd_hi_i = 1; step(1);
    check("R5 end of hold-off", gate_hi_o, 1'b1);

    // R5: restart on reassertion
    cmd_hi_i = 0; uv_boot_i = 1; step(2);
    uv_boot_i = 0; step(1000);
    uv_boot_i = 1; step(1);
    uv_boot_i = 0; step(1000);
    cmd_hi_i = 1; step(1);
    check("R5 restart", gate_hi_o, 1'b0);
    cmd_hi_i = 0; step(400);
    cmd_hi_i = 1; step(1);
    check("R5 after restart", gate_hi_o, 1'b1);

    // R7: freeze and latest level on release
    slew_i = 1; cmd_hi_i = 0; step(3);
    check("R7 frozen high", gate_hi_o, 1'b1);
    cmd_hi_i = 1; step(1);
    cmd_hi_i = 0; step(1);
    slew_i = 0; step(1);
    check("R7 latest low", gate_hi_o, 1'b0);
    slew_i = 1; cmd_hi_i = 1; step(3);
    check("R7 frozen low", gate_hi_o, 1'b0);
    slew_i = 0; step(1);
    check("R7 latest high", gate_hi_o, 1'b1);

    // R10: differential no overlap while frozen
    do_reset(1'b1);
    cmd_hi_i = 1; cmd_lo_i = 0; step(1);
    check("R10 hi on", gate_hi_o, 1'b1);
    slew_i = 1; cmd_hi_i = 0; cmd_lo_i = 1; step(3);
    check("R10 hi frozen", gate_hi_o, 1'b1);
    check("R10 lo held off", gate_lo_o, 1'b0);
    slew_i = 0; step(1);
    check("R10 hi after", gate_hi_o, 1'b0);
    check("R10 lo after", gate_lo_o, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule